// File: doc/BRIEF.md
# Bit-Mapped Framebuffer Scanout

This block stores a monochrome image of 64 columns by 100 rows, one bit per pixel, packed eight pixels to a byte (800 bytes in all). It turns that image into a serial pixel stream for the video-level output of a non-interlaced display. A separate timing generator supplies a one-cycle line strobe and the number of the line that is starting. This block decides whether that line carries image content and which image row belongs to it. It then reads the eight bytes of that row into a shift register and shifts them out at one pixel per four clocks. The result is a 256-clock pixel window in the horizontal middle of the line.

Each image row is repeated on two consecutive scan lines, so the 100 rows cover 200 scan lines starting at a configurable first line. This makes the pixels roughly square. Drawing logic reads and writes image bytes through a byte-wide port. That port is held off with a ready signal only during the eight-cycle row fetch at the start of each displayed line. The sync generator and the analog level conversion sit outside this block.

Top module: `fb_scanout`

## Requirements
- R1: Byte address `row*8 + byte` (0..799) holds pixels of image row `row`, columns `8*byte` to `8*byte+7`. A read accepted on a clock edge (host_rd high while host_rdy high) returns the stored byte on host_rdata with host_rvalid high in the following cycle. An accepted write changes the stored byte.
- R2: Within a row, byte 0 is the leftmost byte, and bit 7 of every byte is its leftmost pixel (shifted out first).
- R3: While the pixel window is open, every pixel stays on pix_out for exactly 4 clocks. The 64 pixels follow one another with no gap, so the window lasts 256 clocks.
- R4: If line_start is high in cycle c on a displayed line, pixel k (0..63) is driven in cycles c+1+H_START+4k through c+4+H_START+4k. With H_START = 152 the window sits in the middle of the visible line.
- R5: Line numbers FIRST_LINE (default 21) through FIRST_LINE+199 are displayed. Line L shows image row (L-FIRST_LINE)/2, so two consecutive lines show the same row.
- R6: On a line outside the displayed range, pix_en and pix_out stay 0 for the whole line and host_rdy stays 1.
- R7: On a displayed line, host_rdy is 0 in cycles c+1 through c+8 and 1 otherwise. A read or write presented while host_rdy is 0 is ignored: the stored byte is unchanged and no host_rvalid follows.
- R8: Outside the pixel window pix_en is 0 and pix_out is 0.
- R9: After reset, pix_en, pix_out and host_rvalid are 0 and host_rdy is 1.
- R10: A write to a row after that row's fetch for the current line has no effect on the current line. It appears from the next line that fetches the row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock (four clocks per pixel) |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe at the start of each scan line |
| line_num | input | 9 | Number of the line that starts with the strobe (1..262) |
| host_rd | input | 1 | Drawing port read request |
| host_wr | input | 1 | Drawing port write request |
| host_addr | input | 10 | Drawing port byte address (row*8 + byte) |
| host_wdata | input | 8 | Drawing port write data |
| host_rdy | output | 1 | Drawing port may be used this cycle |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| pix_en | output | 1 | Pixel window open |
| pix_out | output | 1 | Pixel value (1 = white) |

## Verification
The first image row is loaded with single-bit bytes, all-ones, all-zeros and alternating patterns. A mirrored bit order, a swapped byte order or an off-by-one pixel hold would each produce a distinct mismatch on that row. The remaining rows get an address-derived pattern, so a wrong row computation or a missing line doubling shows up as the wrong row's data on a given line, on both the even and the odd line of a pair and at the top and bottom edges of the displayed range. Lines just outside the range and in the blanking region must stay dark and leave the port ready. A write attempted during the fetch, and another made mid-line, separate the stall behaviour from the prefetch-isolation behaviour.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    // Image geometry
    localparam int unsigned PIX_PER_BYTE = 8;
    localparam int unsigned FB_COLS      = 64;
    localparam int unsigned FB_ROWS      = 100;
    localparam int unsigned ROW_BYTES    = FB_COLS / PIX_PER_BYTE;
    localparam int unsigned FB_BYTES     = FB_ROWS * ROW_BYTES;

    // Derived widths
    localparam int unsigned ADDR_W = $clog2(FB_BYTES);
    localparam int unsigned IDX_W  = $clog2(ROW_BYTES);
    localparam int unsigned ROW_W  = $clog2(FB_ROWS);
    localparam int unsigned PCNT_W = $clog2(FB_COLS);

    typedef logic [PIX_PER_BYTE-1:0] fb_byte_t;

    // Per-line sequencing
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,   // no image on this line, or window finished
        LN_FETCH = 2'd1,   // reading the row bytes into the shifter
        LN_WAIT  = 2'd2,   // row loaded, waiting for the horizontal start
        LN_SHOW  = 2'd3    // shifting pixels out
    } scan_phase_t;

    // Tag returned with each fetched byte: which lane of the shifter it fills
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } fetch_tag_t;

    // Request seen at the storage array from the drawing side
    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        fb_byte_t          wdata;
    } host_req_t;

    // row*ROW_BYTES + idx by concatenation: ROW_BYTES is a power of two
    function automatic logic [ADDR_W-1:0] fb_addr(input logic [ROW_W-1:0] row,
                                                  input logic [IDX_W-1:0] idx);
        return ADDR_W'({row, idx});
    endfunction

endpackage

// File: rtl/fbs_linectl.sv
module fbs_linectl
    import fbs_pkg::*;
#(
    parameter int unsigned LINE_W     = 9,
    parameter int unsigned FIRST_LINE = 21,
    parameter int unsigned H_START    = 152,   // must be at least ROW_BYTES+1
    parameter int unsigned PIX_CLKS   = 4,
    parameter int unsigned REP_SHIFT  = 1      // log2 of scan lines per image row
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    output logic              fetch_en,
    output logic [IDX_W-1:0]  fetch_idx,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              show,
    output logic              shift_tick
);

    localparam int unsigned SHOWN_LINES = FB_ROWS << REP_SHIFT;
    localparam int unsigned LAST_LINE   = FIRST_LINE + SHOWN_LINES - 1;
    localparam int unsigned HCNT_W      = $clog2(H_START + 1);
    localparam int unsigned PH_W        = (PIX_CLKS > 1) ? $clog2(PIX_CLKS) : 1;

    scan_phase_t       st;
    logic [HCNT_W-1:0] hcnt;
    logic [PH_W-1:0]   ph;
    logic [PCNT_W-1:0] pcnt;
    logic [ROW_W-1:0]  row;

    logic              in_rng;
    logic [LINE_W-1:0] rel;
    logic [ROW_W-1:0]  row_next;
    logic              ph_last;

    always_comb begin
        in_rng   = (line_num >= LINE_W'(FIRST_LINE)) && (line_num <= LINE_W'(LAST_LINE));
        rel      = line_num - LINE_W'(FIRST_LINE);
        row_next = ROW_W'(rel >> REP_SHIFT);
        ph_last  = (ph == PH_W'(PIX_CLKS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LN_IDLE;
            hcnt <= '0;
            ph   <= '0;
            pcnt <= '0;
            row  <= '0;
        end else if (line_start) begin
            st   <= in_rng ? LN_FETCH : LN_IDLE;
            hcnt <= '0;
            ph   <= '0;
            pcnt <= '0;
            if (in_rng) row <= row_next;
        end else begin
            unique case (st)
                LN_FETCH: begin
                    hcnt <= hcnt + 1'b1;
                    if (hcnt == HCNT_W'(ROW_BYTES - 1)) st <= LN_WAIT;
                end
                LN_WAIT: begin
                    hcnt <= hcnt + 1'b1;
                    if (hcnt == HCNT_W'(H_START - 1)) st <= LN_SHOW;
                end
                LN_SHOW: begin
                    if (ph_last) begin
                        ph   <= '0;
                        pcnt <= pcnt + 1'b1;
                        if (pcnt == PCNT_W'(FB_COLS - 1)) st <= LN_IDLE;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        fetch_en   = (st == LN_FETCH);
        fetch_idx  = hcnt[IDX_W-1:0];
        fetch_addr = fb_addr(row, fetch_idx);
        show       = (st == LN_SHOW);
        shift_tick = show && ph_last;
    end

endmodule

// File: rtl/fbs_store.sv
module fbs_store
    import fbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic [IDX_W-1:0]  fetch_idx,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  host_req_t         hreq,
    output logic              host_rdy,
    output fb_byte_t          rd_q,
    output logic              host_rvalid,
    output fetch_tag_t        ftag
);

    fb_byte_t          mem [FB_BYTES];
    logic              go_rd;
    logic              go_wr;
    logic [ADDR_W-1:0] rd_addr;

    // The row fetch owns the single array port; the drawing side waits.
    always_comb begin
        host_rdy = !fetch_en;
        go_rd    = hreq.rd && host_rdy;
        go_wr    = hreq.wr && host_rdy && (hreq.addr < ADDR_W'(FB_BYTES));
        rd_addr  = fetch_en ? fetch_addr : hreq.addr;
    end

    always_ff @(posedge clk) begin
        if (go_wr) mem[hreq.addr] <= hreq.wdata;
        rd_q <= mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rvalid <= 1'b0;
            ftag        <= '0;
        end else begin
            host_rvalid <= go_rd;
            ftag.valid  <= fetch_en;
            ftag.idx    <= fetch_idx;
        end
    end

endmodule

// File: rtl/fbs_serial.sv
module fbs_serial
    import fbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fetch_tag_t ftag,
    input  fb_byte_t   fdata,
    input  logic       show,
    input  logic       shift_tick,
    output logic       pix
);

    logic [FB_COLS-1:0] sh;
    logic [FB_COLS-1:0] sh_loaded;

    // One lane per row byte; byte 0 lands in the top lane so it leaves first.
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
        localparam int unsigned HI = FB_COLS - 1 - g * PIX_PER_BYTE;
        always_comb begin
            if (ftag.valid && ftag.idx == IDX_W'(g))
                sh_loaded[HI -: PIX_PER_BYTE] = fdata;
            else
                sh_loaded[HI -: PIX_PER_BYTE] = sh[HI -: PIX_PER_BYTE];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             sh <= '0;
        else if (ftag.valid) sh <= sh_loaded;
        else if (shift_tick) sh <= {sh[FB_COLS-2:0], 1'b0};
    end

    assign pix = show & sh[FB_COLS-1];

endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
    import fbs_pkg::*;
#(
    parameter int unsigned LINE_W     = 9,
    parameter int unsigned FIRST_LINE = 21,
    parameter int unsigned H_START    = 152,
    parameter int unsigned PIX_CLKS   = 4,
    parameter int unsigned REP_SHIFT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic              host_rdy,
    output logic [7:0]        host_rdata,
    output logic              host_rvalid,
    output logic              pix_en,
    output logic              pix_out
);

    logic              fetch_en;
    logic [IDX_W-1:0]  fetch_idx;
    logic [ADDR_W-1:0] fetch_addr;
    logic              show;
    logic              shift_tick;
    host_req_t         hreq;
    fb_byte_t          rd_q;
    fetch_tag_t        ftag;

    always_comb begin
        hreq.rd    = host_rd;
        hreq.wr    = host_wr;
        hreq.addr  = host_addr;
        hreq.wdata = host_wdata;
    end

    fbs_linectl #(
        .LINE_W    (LINE_W),
        .FIRST_LINE(FIRST_LINE),
        .H_START   (H_START),
        .PIX_CLKS  (PIX_CLKS),
        .REP_SHIFT (REP_SHIFT)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .line_num  (line_num),
        .fetch_en  (fetch_en),
        .fetch_idx (fetch_idx),
        .fetch_addr(fetch_addr),
        .show      (show),
        .shift_tick(shift_tick)
    );

    fbs_store u_mem (
        .clk        (clk),
        .rst        (rst),
        .fetch_en   (fetch_en),
        .fetch_idx  (fetch_idx),
        .fetch_addr (fetch_addr),
        .hreq       (hreq),
        .host_rdy   (host_rdy),
        .rd_q       (rd_q),
        .host_rvalid(host_rvalid),
        .ftag       (ftag)
    );

    fbs_serial u_ser (
        .clk       (clk),
        .rst       (rst),
        .ftag      (ftag),
        .fdata     (rd_q),
        .show      (show),
        .shift_tick(shift_tick),
        .pix       (pix_out)
    );

    assign host_rdata = rd_q;
    assign pix_en     = show;

endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
    parameter int unsigned LINE_W     = 9,
    parameter int unsigned FIRST_LINE = 21,
    parameter int unsigned PIX_CLKS   = 4,
    parameter int unsigned REP_SHIFT  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              line_start,
    input logic [LINE_W-1:0] line_num,
    input logic              host_rd,
    input logic              host_rdy,
    input logic              host_rvalid,
    input logic              pix_en,
    input logic              pix_out
);

    localparam int unsigned LAST_LINE = FIRST_LINE + (100 << REP_SHIFT) - 1;

    logic       shown_now;
    logic       line_shown;
    logic [2:0] hold;
    logic [9:0] run;

    assign shown_now = (line_num >= LINE_W'(FIRST_LINE)) && (line_num <= LINE_W'(LAST_LINE));

    always_ff @(posedge clk) begin
        if (rst) begin
            line_shown <= 1'b0;
            hold       <= '0;
            run        <= '0;
        end else begin
            if (line_start) line_shown <= shown_now;
            if (!pix_en)                        hold <= '0;
            else if (hold == 3'(PIX_CLKS - 1))  hold <= '0;
            else                                hold <= hold + 1'b1;
            run <= pix_en ? run + 1'b1 : '0;
        end
    end

    // R8: nothing lit outside the window
    p_dark_outside_r8: assert property (@(posedge clk) disable iff (rst)
        pix_out |-> pix_en);

    // R3: value held for the whole pixel period
    p_pixel_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (pix_en && hold != 3'd0) |-> $stable(pix_out));

    // R3: one window is exactly 64 pixels long
    p_window_len_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(pix_en) |-> (run == 10'd256));

    // R6: a line outside the range never opens the window
    p_offline_dark_r6: assert property (@(posedge clk) disable iff (rst)
        pix_en |-> line_shown);

    // R6: port stays ready when no fetch is needed
    p_offline_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (line_start && !shown_now) |=> host_rdy);

    // R7: fetch holds off the drawing port
    p_fetch_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (line_start && shown_now) |=> !host_rdy);

    // R1: accepted read answers next cycle
    p_read_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_rdy) |=> host_rvalid);

    // R7: stalled or absent read produces no data
    p_no_stray_rvalid_r7: assert property (@(posedge clk) disable iff (rst)
        !(host_rd && host_rdy) |=> !host_rvalid);

endmodule

bind fb_scanout fbs_checker #(
    .LINE_W    (LINE_W),
    .FIRST_LINE(FIRST_LINE),
    .PIX_CLKS  (PIX_CLKS),
    .REP_SHIFT (REP_SHIFT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .line_num   (line_num),
    .host_rd    (host_rd),
    .host_rdy   (host_rdy),
    .host_rvalid(host_rvalid),
    .pix_en     (pix_en),
    .pix_out    (pix_out)
);

// File: tb/sim_fb_scanout.sv
module sim_fb_scanout;
    import fbs_pkg::*;

    localparam int  FIRST    = 21;
    localparam int  HS       = 152;
    localparam int  LINE_CYC = 420;

    logic        clk = 1'b0;
    logic        rst;
    logic        line_start;
    logic [8:0]  line_num;
    logic        host_rd;
    logic        host_wr;
    logic [9:0]  host_addr;
    logic [7:0]  host_wdata;
    logic        host_rdy;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        pix_en;
    logic        pix_out;

    always #4 clk = ~clk;

    fb_scanout u0 (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .line_num   (line_num),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdy   (host_rdy),
        .host_rdata (host_rdata),
        .host_rvalid(host_rvalid),
        .pix_en     (pix_en),
        .pix_out    (pix_out)
    );

    typedef struct {
        longint cyc;
        logic   val;
    } exp_t;

    exp_t     q[$];
    logic [7:0] model [800];
    longint   cyc = 0;
    int       checks = 0;
    int       fails = 0;
    bit       done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the expected pixel for this cycle, flags any light elsewhere
    always @(negedge clk) begin
        if (rst === 1'b0) begin
            if (q.size() != 0 && q[0].cyc == cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(pix_en === 1'b1 && pix_out === e.val, "R2 R3 R4 R5",
                    "pixel", longint'({pix_en, pix_out}), longint'({1'b1, e.val}));
            end else if (pix_en !== 1'b0 || pix_out !== 1'b0) begin
                chk(1'b0, "R8 R6", "light outside window",
                    longint'({pix_en, pix_out}), 0);
            end
        end
    end

    task automatic wr(input int a, input logic [7:0] d);
        host_wr    = 1'b1;
        host_addr  = 10'(a);
        host_wdata = d;
        @(negedge clk);
        host_wr    = 1'b0;
        model[a]   = d;
    endtask

    task automatic rd_chk(input int a, input string req);
        host_rd   = 1'b1;
        host_addr = 10'(a);
        @(negedge clk);
        host_rd   = 1'b0;
        chk(host_rvalid === 1'b1 && host_rdata === model[a], req, "readback",
            longint'({host_rvalid, host_rdata}), longint'({1'b1, model[a]}));
    endtask

    task automatic run_line(input int ln, input bit midwrite);
        longint s;
        bit     disp;
        int     row;
        disp = (ln >= FIRST) && (ln < FIRST + 200);
        row  = (ln - FIRST) >>> 1;
        s    = cyc;
        line_num   = 9'(ln);
        line_start = 1'b1;
        if (disp) begin
            for (int k = 0; k < 64; k++) begin
                logic [7:0] b;
                b = model[row * 8 + k / 8];
                for (int j = 0; j < 4; j++) begin
                    exp_t e;
                    e.cyc = s + 1 + HS + 4 * k + j;
                    e.val = b[7 - (k % 8)];
                    q.push_back(e);
                end
            end
        end
        @(negedge clk);
        line_start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk(host_rdy === !disp, disp ? "R7" : "R6", "rdy during fetch",
                longint'(host_rdy), longint'(!disp));
            if (disp && i == 2) begin
                // R7: this write meets a stalled port and must not land
                host_wr    = 1'b1;
                host_addr  = 10'd799;
                host_wdata = ~model[799];
            end else begin
                host_wr = 1'b0;
            end
            @(negedge clk);
        end
        host_wr = 1'b0;
        chk(host_rdy === 1'b1, "R7", "rdy after fetch", longint'(host_rdy), 1);
        while (cyc < s + LINE_CYC) begin
            if (midwrite && disp && cyc == s + 200)
                wr(row * 8, ~model[row * 8]);   // R10: lands after this line's fetch
            else
                @(negedge clk);
        end
    endtask

    initial begin
        rst        = 1'b1;
        line_start = 1'b0;
        line_num   = '0;
        host_rd    = 1'b0;
        host_wr    = 1'b0;
        host_addr  = '0;
        host_wdata = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: idle state after reset
        chk(pix_en === 1'b0 && pix_out === 1'b0, "R9", "pixel idle",
            longint'({pix_en, pix_out}), 0);
        chk(host_rdy === 1'b1, "R9", "rdy", longint'(host_rdy), 1);
        chk(host_rvalid === 1'b0, "R9", "rvalid", longint'(host_rvalid), 0);

        // Fill the image; row 0 carries bit-order patterns (R2)
        for (int a = 0; a < 800; a++)
            wr(a, 8'((a * 29 + (a >> 3) * 7 + 3) & 8'hFF));
        wr(0, 8'h80); wr(1, 8'h01); wr(2, 8'hFF); wr(3, 8'h00);
        wr(4, 8'hAA); wr(5, 8'h55); wr(6, 8'hC3); wr(7, 8'h3C);

        // R1: addressing and read latency
        rd_chk(0, "R1");
        rd_chk(7, "R1");
        rd_chk(8, "R1");
        rd_chk(400, "R1");
        rd_chk(793, "R1");
        rd_chk(799, "R1");

        run_line(20, 1'b0);   // R6: just before the range
        run_line(21, 1'b0);   // R5: first line, row 0
        run_line(22, 1'b1);   // R5: second copy of row 0; R10 mid-line write
        run_line(21, 1'b0);   // R10: new byte now visible
        run_line(23, 1'b0);   // R5: row 1
        run_line(120, 1'b0);  // R5: row 49
        run_line(219, 1'b0);  // R5: row 99
        run_line(220, 1'b0);  // R5: row 99 again, last displayed line
        run_line(221, 1'b0);  // R6: just past the range
        run_line(249, 1'b0);  // R6: blanking region
        run_line(1, 1'b0);    // R6: top of field

        // R7: the stalled write left byte 799 untouched
        rd_chk(799, "R7");
        chk(q.size() == 0, "R3", "pixels left unseen", longint'(q.size()), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R3 actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule